// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers event signals from a power-management device into a single interrupt request pin. Each of seven 16-bit event slots captures rising edges into sticky status bits. Each slot has its own 16-bit mask. A 16-bit summary word condenses the slots and a set of direct sources into one bit per group. A top-level mask and a polarity setting then decide the level of the request pin.

Software services the pin by reading the summary, then reading the status words it names. A status read returns the captured events and clears them in the same access. The pin is a level and not a pulse. It stays asserted for as long as any enabled event is pending, so an event that arrives during servicing is never dropped.

Groups 0 to 6 of the summary come from the slots. Groups 7 to 15 follow direct level sources that have no status word of their own. Some mask bits are fixed by parameter and ignore writes.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the pin is driven high, which is deasserted at the reset polarity. Every writable slot mask bit reads 1. The top mask at address 0x01 reads 0xFFFF. The control word at 0x02 reads 0, and the summary at 0x00 reads 0.
- R2: A 0-to-1 transition on event input bit b of slot g sets bit b of the status word at address 0x10+g on the next clock edge.
- R3: A read of 0x10+g returns that status word, with one cycle of latency on rdata_o, and clears it.
- R4: If an event sets a status bit in the same cycle as that slot's read-clear, the bit survives and appears in the next read.
- R5: An event input that stays high sets its status bit only once. After the bit is cleared it stays clear until the next rising transition.
- R6: Summary bit g (g<7) is 1 exactly when slot g has a status bit set whose mask bit at 0x18+g is 0. A mask bit of 1 blocks the event.
- R7: Fixed mask bits ignore writes. By default, slot 3 bits 15:12 always read 1 and slot 5 bits 15:13 always read 0.
- R8: The request is active when some summary bit is set whose top-mask bit is 0.
- R9: Control bit 0 selects the polarity. 1 drives the pin high when the request is active. 0 drives it low when active and high when idle.
- R10: Summary bits 15:7 follow direct_i[8:0], registered one cycle, and they are not cleared by any read.
- R11: Writes to the summary and status addresses have no effect. Reads of unmapped addresses return 0.
- R12: The pin stays asserted while any enabled event is pending. It deasserts only after the last one is cleared, and it reasserts when a new one arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 112 | Event sources; slot g uses bits g*16+15 : g*16 |
| direct_i | input | 9 | Level sources for summary bits 15:7 |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Interrupt request pin |

## Verification
The assertions assume that the event and direct inputs are synchronous to clk. They also assume that every input is low while reset is applied, so that no edge is counted at reset release. The bench changes all inputs only on the falling clock edge and holds events and direct sources at 0 during reset. Register accesses use one-cycle strobes, and a read can coincide with a new event, which exercises the case where the set and the clear of a status bit collide.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int REG_W   = 16;
    localparam int N_SLOT  = 7;
    localparam int ADR_W   = 8;
    localparam int A_SUM    = 8'h00;
    localparam int A_TOPMSK = 8'h01;
    localparam int A_CTRL   = 8'h02;
    localparam int A_STAT0  = 8'h10;
    localparam int A_MASK0  = 8'h18;
    // fixed mask bits, slot 6 in the top 16 bits down to slot 0
    localparam logic [N_SLOT*REG_W-1:0] LOCK_MASK_DEF =
        {16'h0000, 16'hE000, 16'h0000, 16'hF000, 16'h0000, 16'h0000, 16'h0000};
    localparam logic [N_SLOT*REG_W-1:0] LOCK_VAL_DEF =
        {16'h0000, 16'h0000, 16'h0000, 16'hF000, 16'h0000, 16'h0000, 16'h0000};
endpackage

// File: rtl/irq_slot.sv
module irq_slot #(
    parameter int W = 16,
    parameter logic [W-1:0] LOCK_MASK = '0,
    parameter logic [W-1:0] LOCK_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         rd_clr_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] mask_o,
    output logic         pend_o
);
    localparam logic [W-1:0] RST_MASK = ~LOCK_MASK | (LOCK_VAL & LOCK_MASK);

    typedef struct packed {
        logic [W-1:0] st;
        logic [W-1:0] mk;
        logic [W-1:0] prev;
    } slot_t;

    slot_t s_d, s_q;
    logic [W-1:0] rise;

    always_comb begin
        s_d    = s_q;
        rise   = evt_i & ~s_q.prev;
        s_d.prev = evt_i;
        // a new edge wins over the read-clear
        s_d.st = (rd_clr_i ? '0 : s_q.st) | rise;
        if (wr_en_i) begin
            s_d.mk = (wdata_i & ~LOCK_MASK) | (LOCK_VAL & LOCK_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= '0;
            s_q.mk   <= RST_MASK;
            s_q.prev <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status_o = s_q.st;
    assign mask_o   = s_q.mk;
    assign pend_o   = |(s_q.st & ~s_q.mk);
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
    parameter int W     = 16,
    parameter int NSLOT = 7
) (
    input  logic [NSLOT-1:0]   pend_i,
    input  logic [W-NSLOT-1:0] dir_i,
    input  logic [W-1:0]       top_mask_i,
    input  logic               pol_i,
    output logic [W-1:0]       summary_o,
    output logic               irq_o
);
    logic act;

    always_comb begin
        summary_o = {dir_i, pend_i};
        act       = |(summary_o & ~top_mask_i);
        irq_o     = pol_i ? act : ~act;
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int W     = REG_W,
    parameter int NSLOT = N_SLOT,
    parameter int AW    = ADR_W,
    parameter logic [NSLOT*W-1:0] LOCK_MASK = LOCK_MASK_DEF,
    parameter logic [NSLOT*W-1:0] LOCK_VAL  = LOCK_VAL_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSLOT*W-1:0]   evt_i,
    input  logic [W-NSLOT-1:0]   direct_i,
    input  logic                 sel_i,
    input  logic                 wr_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [W-1:0]         wdata_i,
    output logic [W-1:0]         rdata_o,
    output logic                 irq_o
);
    localparam int DIR_W = W - NSLOT;

    typedef struct packed {
        logic [W-1:0]     top_mask;
        logic             pol;
        logic [DIR_W-1:0] dir;
        logic [W-1:0]     rdata;
    } ctl_t;

    ctl_t c_d, c_q;
    logic             rd_en, wr_en;
    logic [NSLOT-1:0] slot_rd, slot_wr, pend;
    logic [NSLOT*W-1:0] st_flat, mk_flat;
    logic [W-1:0]     summary, rd_val;

    assign rd_en = sel_i & ~wr_i;
    assign wr_en = sel_i & wr_i;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign slot_rd[g] = rd_en && (addr_i == AW'(A_STAT0 + g));
        assign slot_wr[g] = wr_en && (addr_i == AW'(A_MASK0 + g));

        irq_slot #(
            .W(W),
            .LOCK_MASK(LOCK_MASK[g*W +: W]),
            .LOCK_VAL(LOCK_VAL[g*W +: W])
        ) u_slot (
            .clk(clk),
            .rst_n(rst_n),
            .evt_i(evt_i[g*W +: W]),
            .rd_clr_i(slot_rd[g]),
            .wr_en_i(slot_wr[g]),
            .wdata_i(wdata_i),
            .status_o(st_flat[g*W +: W]),
            .mask_o(mk_flat[g*W +: W]),
            .pend_o(pend[g])
        );
    end

    irq_summary #(.W(W), .NSLOT(NSLOT)) u_sum (
        .pend_i(pend),
        .dir_i(c_q.dir),
        .top_mask_i(c_q.top_mask),
        .pol_i(c_q.pol),
        .summary_o(summary),
        .irq_o(irq_o)
    );

    always_comb begin
        rd_val = '0;
        if (addr_i == AW'(A_SUM))         rd_val = summary;
        else if (addr_i == AW'(A_TOPMSK)) rd_val = c_q.top_mask;
        else if (addr_i == AW'(A_CTRL))   rd_val = W'(c_q.pol);
        for (int g = 0; g < NSLOT; g++) begin
            if (addr_i == AW'(A_STAT0 + g)) rd_val = st_flat[g*W +: W];
            if (addr_i == AW'(A_MASK0 + g)) rd_val = mk_flat[g*W +: W];
        end
    end

    always_comb begin
        c_d     = c_q;
        c_d.dir = direct_i;
        if (rd_en) c_d.rdata = rd_val;
        if (wr_en && addr_i == AW'(A_TOPMSK)) c_d.top_mask = wdata_i;
        if (wr_en && addr_i == AW'(A_CTRL))   c_d.pol      = wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.top_mask <= '1;
            c_q.pol      <= 1'b0;
            c_q.dir      <= '0;
            c_q.rdata    <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rdata_o = c_q.rdata;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
    parameter int W     = 16,
    parameter int NSLOT = 7,
    parameter logic [NSLOT*W-1:0] LOCK_MASK = '0,
    parameter logic [NSLOT*W-1:0] LOCK_VAL  = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NSLOT*W-1:0] evt_i,
    input logic [W-NSLOT-1:0] direct_i,
    input logic [NSLOT*W-1:0] st_flat,
    input logic [NSLOT*W-1:0] mk_flat,
    input logic [W-1:0]       summary,
    input logic [W-1:0]       top_mask,
    input logic               pol,
    input logic               irq_o
);
    logic [NSLOT*W-1:0] ev_prev, rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_prev <= '0;
        else        ev_prev <= evt_i;
    end
    assign rise = evt_i & ~ev_prev;

    // R2
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> (($past(rise) & ~st_flat) == '0));

    for (genvar g = 0; g < NSLOT; g++) begin : g_chk
        // R6
        pend_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            summary[g] == (|(st_flat[g*W +: W] & ~mk_flat[g*W +: W])));
    end

    // R7
    lock_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mk_flat ^ LOCK_VAL) & LOCK_MASK) == '0);

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((summary & ~top_mask) == '0) |-> (irq_o == !pol));

    // R10
    direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (summary[W-1:NSLOT] == $past(direct_i)));
endmodule

bind irq_aggregator irq_agg_chk #(
    .W(W), .NSLOT(NSLOT), .LOCK_MASK(LOCK_MASK), .LOCK_VAL(LOCK_VAL)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .evt_i(evt_i),
    .direct_i(direct_i),
    .st_flat(st_flat),
    .mk_flat(mk_flat),
    .summary(summary),
    .top_mask(c_q.top_mask),
    .pol(c_q.pol),
    .irq_o(irq_o)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [111:0] evt_i;
    logic [8:0]   direct_i = '0;
    logic         sel_i = 1'b0;
    logic         wr_i = 1'b0;
    logic [7:0]   addr_i = '0;
    logic [15:0]  wdata_i = '0;
    logic [15:0]  rdata_o;
    logic         irq_o;

    logic [15:0] ev [7];
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int g = 0; g < 7; g++) evt_i[g*16 +: 16] = ev[g];
    end

    irq_aggregator i_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .direct_i(direct_i),
        .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    // ---------------- reference model ----------------
    logic [15:0] m_st [7];
    logic [15:0] m_mk [7];
    logic [15:0] m_prev [7];
    logic [15:0] m_top, m_rd;
    logic        m_pol;
    logic [8:0]  m_dir;

    function automatic logic [15:0] lockm(int g);
        if (g == 3) return 16'hF000;
        if (g == 5) return 16'hE000;
        return 16'h0000;
    endfunction
    function automatic logic [15:0] lockv(int g);
        return (g == 3) ? 16'hF000 : 16'h0000;
    endfunction

    function automatic logic [15:0] m_sum();
        logic [15:0] s = '0;
        for (int g = 0; g < 7; g++) s[g] = |(m_st[g] & ~m_mk[g]);
        s[15:7] = m_dir;
        return s;
    endfunction

    function automatic logic [15:0] m_read(int a);
        if (a == 0) return m_sum();
        if (a == 1) return m_top;
        if (a == 2) return {15'b0, m_pol};
        if (a >= 16 && a < 23) return m_st[a-16];
        if (a >= 24 && a < 31) return m_mk[a-24];
        return 16'h0000;
    endfunction

    function automatic logic m_irq();
        logic act = |(m_sum() & ~m_top);
        return m_pol ? act : ~act;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < 7; g++) begin
                m_st[g] = '0; m_prev[g] = '0;
                m_mk[g] = ~lockm(g) | (lockv(g) & lockm(g));
            end
            m_top = 16'hFFFF; m_pol = 1'b0; m_dir = '0; m_rd = '0;
        end else begin
            if (sel_i && !wr_i) m_rd = m_read(int'(addr_i));
            for (int g = 0; g < 7; g++) begin
                logic clr;
                clr = sel_i && !wr_i && (int'(addr_i) == 16 + g);
                m_st[g] = (clr ? 16'h0 : m_st[g]) | (ev[g] & ~m_prev[g]);
                m_prev[g] = ev[g];
                if (sel_i && wr_i && int'(addr_i) == 24 + g)
                    m_mk[g] = (wdata_i & ~lockm(g)) | (lockv(g) & lockm(g));
            end
            if (sel_i && wr_i && addr_i == 8'h01) m_top = wdata_i;
            if (sel_i && wr_i && addr_i == 8'h02) m_pol = wdata_i[0];
            m_dir = direct_i;
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R12 model comparison on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R12 model irq", {15'b0, irq_o}, {15'b0, m_irq()});
            chk("R3 model rdata", rdata_o, m_rd);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk); sel_i = 1; wr_i = 0; addr_i = a;
        @(negedge clk); sel_i = 0;
        d = rdata_o;
    endtask
    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
        @(negedge clk); sel_i = 0; wr_i = 0;
    endtask
    task automatic pulse(int g, int b);
        @(negedge clk); ev[g][b] = 1'b1;
        @(negedge clk); ev[g][b] = 1'b0;
    endtask
    // read of a status word in the same cycle as a new edge on that slot
    task automatic rd_with_evt(int g, int b, output logic [15:0] d);
        @(negedge clk); sel_i = 1; wr_i = 0; addr_i = 8'(16 + g); ev[g][b] = 1'b1;
        @(negedge clk); sel_i = 0; ev[g][b] = 1'b0;
        d = rdata_o;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        for (int g = 0; g < 7; g++) ev[g] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq idle", {15'b0, irq_o}, 16'h0001);
        rd(8'h18, d); chk("R1 mask0", d, 16'hFFFF);
        rd(8'h1B, d); chk("R1 mask3", d, 16'hFFFF);
        rd(8'h1D, d); chk("R1 mask5", d, 16'h1FFF);
        rd(8'h01, d); chk("R1 topmask", d, 16'hFFFF);
        rd(8'h02, d); chk("R1 ctrl", d, 16'h0000);
        rd(8'h00, d); chk("R1 summary", d, 16'h0000);

        // R2 / R3 latch and clear on read
        pulse(0, 3);
        rd(8'h10, d); chk("R2 status latch", d, 16'h0008);
        rd(8'h10, d); chk("R3 cleared", d, 16'h0000);

        // R5 held level sets once
        @(negedge clk); ev[1][0] = 1'b1;
        repeat (2) @(negedge clk);
        rd(8'h11, d); chk("R5 first", d, 16'h0001);
        rd(8'h11, d); chk("R5 no reset", d, 16'h0000);
        @(negedge clk); ev[1][0] = 1'b0;

        // R4 set beats clear
        rd_with_evt(2, 1, d); chk("R4 read old", d, 16'h0000);
        rd(8'h12, d); chk("R4 kept", d, 16'h0002);

        // R6 slot mask, R8 top mask
        pulse(4, 2);
        rd(8'h00, d); chk("R6 masked", d, 16'h0000);
        wr(8'h1C, 16'hFFFB);
        rd(8'h00, d); chk("R6 unmasked", d, 16'h0010);
        chk("R8 top masked", {15'b0, irq_o}, 16'h0001);
        wr(8'h01, 16'hFFEF);
        chk("R8 asserted", {15'b0, irq_o}, 16'h0000);
        rd(8'h14, d); chk("R3 slot4", d, 16'h0004);
        chk("R12 deassert", {15'b0, irq_o}, 16'h0001);

        // R12 new event during servicing
        pulse(4, 2);
        chk("R12 asserted", {15'b0, irq_o}, 16'h0000);
        rd_with_evt(4, 2, d); chk("R12 read", d, 16'h0004);
        chk("R12 stays", {15'b0, irq_o}, 16'h0000);
        rd(8'h14, d);
        chk("R12 released", {15'b0, irq_o}, 16'h0001);

        // R9 polarity
        wr(8'h02, 16'h0001);
        chk("R9 high idle", {15'b0, irq_o}, 16'h0000);
        pulse(4, 2);
        chk("R9 high active", {15'b0, irq_o}, 16'h0001);
        rd(8'h14, d);
        chk("R9 high cleared", {15'b0, irq_o}, 16'h0000);
        wr(8'h02, 16'h0000);
        chk("R9 low idle", {15'b0, irq_o}, 16'h0001);

        // R7 fixed mask bits
        wr(8'h1B, 16'h0000);
        rd(8'h1B, d); chk("R7 slot3", d, 16'hF000);
        wr(8'h1D, 16'hFFFF);
        rd(8'h1D, d); chk("R7 slot5", d, 16'hE000 ^ 16'hFFFF);
        pulse(5, 15);
        rd(8'h00, d); chk("R7 fixed enable", d, 16'h0020);
        rd(8'h15, d); chk("R7 slot5 status", d, 16'h8000);

        // R10 direct sources
        @(negedge clk); direct_i = 9'h001;
        @(negedge clk);
        rd(8'h00, d); chk("R10 direct", d, 16'h0080);
        chk("R10 masked", {15'b0, irq_o}, 16'h0001);
        wr(8'h01, 16'hFF7F);
        chk("R10 asserted", {15'b0, irq_o}, 16'h0000);
        rd(8'h00, d); chk("R10 not cleared", d, 16'h0080);
        @(negedge clk); direct_i = 9'h000;
        @(negedge clk);
        chk("R10 follows", {15'b0, irq_o}, 16'h0001);

        // R11 ignored writes, unmapped reads
        pulse(0, 1);
        wr(8'h10, 16'h0000);
        wr(8'h00, 16'hFFFF);
        rd(8'h00, d); chk("R11 summary write", d, 16'h0000);
        rd(8'h10, d); chk("R11 status write", d, 16'h0002);
        wr(8'h30, 16'h0000);
        rd(8'h30, d); chk("R11 unmapped", d, 16'h0000);
        rd(8'h18, d); chk("R11 mask0 intact", d, 16'hFFFF);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule